// File: doc/BRIEF.md
# Interval and Pulse-Count Timer

This block is a 16-bit down-counter paired with a 16-bit reload latch. It is used as a general timer beside a host bus decoder. In time-base mode it counts down once per clock and, on passing below zero, refills itself from the latch. In pulse-count mode it counts falling edges seen on a single external count pin and raises its flag when the count arrives at zero.

The host writes the latch one byte at a time through single-cycle strobes. The high-byte strobe also moves the whole latch into the counter and arms the one-shot flag. A programmable start delay can hold the counter still for a number of clocks after such a load. The counter is always visible on `count_q`, and a read-acknowledge strobe clears the flag.

No data stream crosses this block's edge, so it has no valid/ready interface. Every strobe is taken in the cycle it is high and there is no back-pressure, because the timer can always accept a host access. The external decoder supplies the mode bit and the count pin as plain signals.

Top module: `tmr_interval_timer`

## Requirements
- R1: After reset `count_q` is 0xFFFF, the latch is 0xFFFF and `irq_flag` is 0. The stored count-pin sample resets high, so a pin that is low in the first counted cycle is taken as a falling edge.
- R2: `lo_wr` writes `wdata` into the latch low byte. `hi_wr` writes `wdata` into the latch high byte and, on the same edge, loads the counter with {`wdata`, latch low byte}.
- R3: With `pulse_mode`=0 (time-base) and no hold active, a nonzero counter drops by one on every clock.
- R4: In time-base mode a counter at 0 takes the latch value on the next counted edge; it never shows 0xFFFF.
- R5: In time-base mode an underflow sets `irq_flag` one clock after the reload edge, but only for the first underflow after an `hi_wr`. Later underflows keep reloading without setting the flag.
- R6: With `pulse_mode`=1 the counter drops by one only on a clock where `count_pin` is low and was high in the previous cycle. A steady level leaves it unchanged.
- R7: In pulse mode the edge that brings the counter to 0 sets `irq_flag` on that same edge. The following falling edge wraps the counter to 0xFFFF, with no reload.
- R8: `hi_wr` loads a hold count from `start_delay`. For that many clocks after the load the counter stays at its loaded value, and then counting resumes.
- R9: `hi_wr` clears `irq_flag` and cancels a time-base flag that is still one clock from appearing.
- R10: `rd_ack` clears `irq_flag` unless a flag-setting event lands in the same cycle, in which case the flag stays set.
- R11: When `lo_wr` and `hi_wr` are both high in one cycle, the counter takes the old latch low byte and the latch takes `wdata` in both bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_mode | input | 1 | 0 = time-base counting, 1 = falling-edge counting |
| count_pin | input | 1 | External count pin sampled every clock |
| wdata | input | 8 | Host write byte |
| lo_wr | input | 1 | Write latch low byte |
| hi_wr | input | 1 | Write latch high byte and load counter |
| start_delay | input | 8 | Hold count taken on `hi_wr` |
| rd_ack | input | 1 | Host read of the low byte; clears the flag |
| count_q | output | 16 | Current counter value |
| irq_flag | output | 1 | Expiry flag |

## Verification
A wrong counter or latch bit shows on `count_q` within one clock of the edge that used it, or at the next reload. A wrong armed or pending state stays hidden until the next underflow, which is up to the latch value plus the hold count plus two clocks later, and then shows as a flag that is missing or repeated. A wrong pin sample shows as a count that is gained or lost on the next level change of `count_pin`. The reference model is compared on every clock, and long random runs with short reload values put many underflows and edges inside that window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic {
    TMR_TIMED = 1'b0,
    TMR_PULSE = 1'b1
  } tmr_mode_e;

  typedef struct packed {
    logic timed_evt;
    logic pulse_evt;
  } tmr_evt_t;

endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic fall
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin_in;
  end

  assign fall = pin_q & ~pin_in;
endmodule

// File: rtl/tmr_start_delay.sv
module tmr_start_delay #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             hold
);
  localparam logic [DLY_W-1:0] DLY_ONE = {{(DLY_W-1){1'b0}}, 1'b1};

  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dly_q <= '0;
    else if (load)          dly_q <= load_val;
    else if (dly_q != '0)   dly_q <= dly_q - DLY_ONE;
  end

  assign hold = (dly_q != '0);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              step,
  input  logic              fall,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  latch_q,
  output tmr_evt_t          evt
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d, lat_q, lat_d;
  logic             armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    lat_d   = lat_q;
    armed_d = armed_q;
    evt     = '0;
    if (step) begin
      if (mode == TMR_TIMED) begin
        if (cnt_q == '0) begin
          cnt_d = lat_q;
          if (armed_q) begin
            evt.timed_evt = 1'b1;
            armed_d       = 1'b0;
          end
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end else if (fall) begin
        cnt_d         = cnt_q - CNT_ONE;
        evt.pulse_evt = (cnt_q == CNT_ONE);
      end
    end
    if (lo_wr) lat_d[DATA_W-1:0] = wdata;
    if (hi_wr) begin
      lat_d[CNT_W-1:DATA_W] = wdata;
      cnt_d                 = {wdata, lat_q[DATA_W-1:0]};
      armed_d               = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      lat_q   <= '1;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      lat_q   <= lat_d;
      armed_q <= armed_d;
    end
  end

  assign count_q = cnt_q;
  assign latch_q = lat_q;
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  tmr_evt_t evt,
  input  logic     hi_wr,
  input  logic     rd_ack,
  output logic     pend_q,
  output logic     irq_flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (hi_wr) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pend_q <= evt.timed_evt;
      flag_q <= pend_q | evt.pulse_evt | (flag_q & ~rd_ack);
    end
  end

  assign irq_flag = flag_q;
endmodule

// File: rtl/tmr_interval_timer.sv
module tmr_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DLY_W  = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_mode,
  input  logic              count_pin,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [DLY_W-1:0]  start_delay,
  input  logic              rd_ack,
  output logic [CNT_W-1:0]  count_q,
  output logic              irq_flag
);
  tmr_mode_e        mode;
  logic             pin_fall;
  logic             delay_hold;
  logic             count_step;
  logic [CNT_W-1:0] latch_q;
  tmr_evt_t         evt;
  logic             pend_q;
  logic             pulse_evt;

  assign mode       = tmr_mode_e'(pulse_mode);
  assign count_step = ~delay_hold & ~hi_wr;
  assign pulse_evt  = evt.pulse_evt;

  tmr_pin_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (count_pin),
    .fall   (pin_fall)
  );

  tmr_start_delay #(.DLY_W(DLY_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hi_wr),
    .load_val (start_delay),
    .hold     (delay_hold)
  );

  tmr_count_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .step    (count_step),
    .fall    (pin_fall),
    .lo_wr   (lo_wr),
    .hi_wr   (hi_wr),
    .wdata   (wdata),
    .count_q (count_q),
    .latch_q (latch_q),
    .evt     (evt)
  );

  tmr_flag_unit u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .hi_wr    (hi_wr),
    .rd_ack   (rd_ack),
    .pend_q   (pend_q),
    .irq_flag (irq_flag)
  );
endmodule

// File: rtl/tmr_interval_timer_chk.sv
module tmr_interval_timer_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pulse_mode,
  input logic              hi_wr,
  input logic              rd_ack,
  input logic [DATA_W-1:0] wdata,
  input logic [CNT_W-1:0]  count_q,
  input logic              irq_flag,
  input logic [CNT_W-1:0]  latch_q,
  input logic              pend_q,
  input logic              step,
  input logic              fall,
  input logic              hold,
  input logic              pulse_evt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_hi_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> count_q == {$past(wdata), $past(latch_q[DATA_W-1:0])});

  assert_timed_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && step && count_q != '0) |=> count_q == $past(count_q) - ONE);

  assert_timed_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && step && count_q == '0) |=> count_q == $past(latch_q));

  assert_pend_to_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !hi_wr) |=> irq_flag);

  assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(pend_q || pulse_evt));

  assert_pulse_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && step && !fall) |=> $stable(count_q));

  assert_pulse_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_evt |=> (irq_flag && count_q == '0));

  assert_delay_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !hi_wr) |=> $stable(count_q));

  assert_load_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> !irq_flag);

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !pend_q && !pulse_evt) |=> !irq_flag);
endmodule

bind tmr_interval_timer tmr_interval_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pulse_mode (pulse_mode),
  .hi_wr      (hi_wr),
  .rd_ack     (rd_ack),
  .wdata      (wdata),
  .count_q    (count_q),
  .irq_flag   (irq_flag),
  .latch_q    (latch_q),
  .pend_q     (pend_q),
  .step       (count_step),
  .fall       (pin_fall),
  .hold       (delay_hold),
  .pulse_evt  (pulse_evt)
);

// File: tb/tmr_interval_timer_bench.sv
module tmr_interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_mode = 1'b0;
  logic        count_pin = 1'b1;
  logic [7:0]  wdata = 8'h00;
  logic        lo_wr = 1'b0;
  logic        hi_wr = 1'b0;
  logic [7:0]  start_delay = 8'h00;
  logic        rd_ack = 1'b0;
  logic [15:0] count_q;
  logic        irq_flag;

  always #10 clk = ~clk;

  tmr_interval_timer u_tmr_interval_timer (
    .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode), .count_pin(count_pin),
    .wdata(wdata), .lo_wr(lo_wr), .hi_wr(hi_wr), .start_delay(start_delay),
    .rd_ack(rd_ack), .count_q(count_q), .irq_flag(irq_flag)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    sb_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  logic [15:0] m_cnt = 16'hFFFF, m_lat = 16'hFFFF;
  int          m_dly = 0;
  bit          m_armed = 0, m_flag = 0, m_pend = 0, m_pin = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 16'hFFFF; m_lat = 16'hFFFF; m_dly = 0;
      m_armed = 0; m_flag = 0; m_pend = 0; m_pin = 1;
    end else begin
      bit          edge_seen, nflag, npend, narmed;
      logic [15:0] ncnt, nlat;
      int          ndly;
      edge_seen = m_pin && !count_pin;
      nflag  = (m_flag && !rd_ack) || m_pend;
      npend  = 0;
      narmed = m_armed;
      ncnt   = m_cnt;
      nlat   = m_lat;
      ndly   = (m_dly > 0) ? m_dly - 1 : 0;
      if (m_dly == 0 && !hi_wr) begin
        if (!pulse_mode) begin
          if (m_cnt == 16'h0000) begin
            ncnt = m_lat;
            if (m_armed) begin npend = 1; narmed = 0; end
          end else ncnt = m_cnt - 16'd1;
        end else if (edge_seen) begin
          ncnt = m_cnt - 16'd1;
          if (ncnt == 16'h0000) nflag = 1;
        end
      end
      if (lo_wr) nlat[7:0] = wdata;
      if (hi_wr) begin
        ncnt = {wdata, m_lat[7:0]};
        nlat[15:8] = wdata;
        narmed = 1; nflag = 0; npend = 0;
        ndly = int'(start_delay);
      end
      m_cnt = ncnt; m_lat = nlat; m_dly = ndly;
      m_armed = narmed; m_flag = nflag; m_pend = npend; m_pin = count_pin;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && sb_on && !done) begin
      n_cmp++;
      if (count_q !== m_cnt || irq_flag !== m_flag) begin
        n_bad++;
        $display("FAIL %s cycle %0d: actual count=%h flag=%b expected count=%h flag=%b",
                 cur_req, cyc, count_q, irq_flag, m_cnt, m_flag);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic next();
    @(negedge clk);
  endtask

  function automatic void finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  logic [31:0] rs = 32'h1234_5678;
  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  initial begin
    repeat (3) next();
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 count", count_q, 16'hFFFF);
    chk("R1 flag", irq_flag, 0);
    sb_on = 1'b1;
    pulse_mode = 1'b1; count_pin = 1'b0;
    next();
    chk("R1 pin sample high", count_q, 16'hFFFE);
    count_pin = 1'b1;

    // R2 latch and load
    cur_req = "R2";
    pulse_mode = 1'b0; lo_wr = 1'b1; wdata = 8'h05;
    next(); lo_wr = 1'b0; hi_wr = 1'b1; wdata = 8'h00; start_delay = 8'd0;
    next(); hi_wr = 1'b0;
    chk("R2 load", count_q, 16'h0005);
    chk("R2 flag", irq_flag, 0);

    // R3 R4 R5 time-base
    cur_req = "R3";
    next(); chk("R3 dec", count_q, 16'h0004);
    repeat (4) next();
    chk("R3 zero", count_q, 16'h0000);
    cur_req = "R4";
    next(); chk("R4 reload", count_q, 16'h0005);
    chk("R5 lag", irq_flag, 0);
    cur_req = "R5";
    next(); chk("R5 set", irq_flag, 1);
    chk("R5 count", count_q, 16'h0004);

    // R10 ack clears
    cur_req = "R10";
    rd_ack = 1'b1; next(); rd_ack = 1'b0;
    chk("R10 clear", irq_flag, 0);
    cur_req = "R5";
    repeat (8) next();
    chk("R5 once per load", irq_flag, 0);

    // R8 start delay
    cur_req = "R8";
    hi_wr = 1'b1; wdata = 8'h00; start_delay = 8'd3;
    next(); hi_wr = 1'b0; start_delay = 8'd0;
    chk("R8 loaded", count_q, 16'h0005);
    repeat (3) next();
    chk("R8 held", count_q, 16'h0005);
    next(); chk("R8 resumes", count_q, 16'h0004);

    // R6 R7 pulse mode
    cur_req = "R6";
    pulse_mode = 1'b1; count_pin = 1'b1; lo_wr = 1'b1; wdata = 8'h02;
    next(); lo_wr = 1'b0; hi_wr = 1'b1; wdata = 8'h00;
    next(); hi_wr = 1'b0;
    chk("R6 load", count_q, 16'h0002);
    repeat (3) next();
    chk("R6 high level holds", count_q, 16'h0002);
    count_pin = 1'b0; next();
    chk("R6 falling edge", count_q, 16'h0001);
    next(); chk("R6 low level holds", count_q, 16'h0001);
    cur_req = "R7";
    count_pin = 1'b1; next(); count_pin = 1'b0; next();
    chk("R7 zero", count_q, 16'h0000);
    chk("R7 flag at once", irq_flag, 1);
    count_pin = 1'b1; next(); count_pin = 1'b0; next();
    chk("R7 wrap", count_q, 16'hFFFF);
    chk("R7 flag kept", irq_flag, 1);
    count_pin = 1'b1;

    // R9 load clears flag and pending flag
    cur_req = "R9";
    hi_wr = 1'b1; wdata = 8'h00; next(); hi_wr = 1'b0;
    chk("R9 clear", irq_flag, 0);
    pulse_mode = 1'b0; lo_wr = 1'b1; wdata = 8'h01;
    next(); lo_wr = 1'b0; hi_wr = 1'b1; wdata = 8'h00;
    next(); hi_wr = 1'b0;
    chk("R9 load one", count_q, 16'h0001);
    next(); next();
    hi_wr = 1'b1; next(); hi_wr = 1'b0;
    chk("R9 pending cancelled", irq_flag, 0);
    next(); chk("R9 stays clear", irq_flag, 0);

    // R11 simultaneous byte writes
    cur_req = "R11";
    pulse_mode = 1'b1; count_pin = 1'b1; lo_wr = 1'b1; hi_wr = 1'b1; wdata = 8'h07;
    next(); lo_wr = 1'b0; hi_wr = 1'b0;
    chk("R11 old low byte", count_q, 16'h0701);

    // R10 set wins over ack
    cur_req = "R10";
    lo_wr = 1'b1; wdata = 8'h01; next(); lo_wr = 1'b0;
    hi_wr = 1'b1; wdata = 8'h00; next(); hi_wr = 1'b0;
    count_pin = 1'b0; rd_ack = 1'b1; next(); rd_ack = 1'b0; count_pin = 1'b1;
    chk("R10 count", count_q, 16'h0000);
    chk("R10 set wins", irq_flag, 1);

    // mixed random traffic against the model
    cur_req = "R3/R5/R7/R8/R10 random";
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = rnd();
      hi_wr       = (r[5:0] == 6'd0);
      lo_wr       = (r[9:6] == 4'd0);
      rd_ack      = (r[12:10] == 3'd0);
      count_pin   = r[13];
      start_delay = {6'd0, r[15:14]};
      wdata       = hi_wr ? {7'd0, (r[18:16] == 3'd0)} : {4'd0, r[23:20]};
      if (r[31:26] == 6'd0) pulse_mode = ~pulse_mode;
      next();
    end
    hi_wr = 1'b0; lo_wr = 1'b0; rd_ack = 1'b0;
    next();
    finish_run();
  end
endmodule